// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block holds the 32-bit status and control word of one downstream root-hub port, as a simple register bus sees it. Bits in the same word follow different write rules. Some mirror hardware status and cannot be written. Some are ordinary read/write controls. One can only be set by software and is cleared by hardware. A group of sticky change flags is cleared by writing one. The link-state field takes a software write only when a strobe bit in the same write qualifies it. Several bits are reserved and always read as zero.

Hardware reports connect, over-current, speed, removability, link-state updates and reset completion, plus warm-reset, port-error and configuration-error events. The block records each such event in its change flag. The block drives port power, the requested link state with a one-cycle request pulse, and the port-reset request.

Software writes take effect on the next clock edge. `rdData` is a combinational view of the stored state, so a value written is visible in the cycle after the write.

Top module: `port_status_reg`

## Requirements
- R1: Bits 0 (connected), 3 (over-current), 13:10 (speed) and 30 (removable) show `hwConnect`, `hwOverCurrent`, `hwSpeed` and `hwRemovable` one clock after those inputs are sampled. Software writes to these bits are ignored.
- R2: Bit 9 (power), bits 15:14 (indicator) and bits 27:25 (wake on connect, disconnect and over-current) take the written value on every write. Bit 9 drives `portPower`.
- R3: Bits 8:5 (link state) change on a software write only when the same write has bit 16 = 1 and bit 9 = 1. An accepted write pulses `linkReqValid` for one cycle and updates `linkStateReq`.
- R4: `hwLinkValid` loads `hwLinkState` into bits 8:5 and sets bit 22. It takes priority over a software link write in the same cycle, and that software write then gives no `linkReqValid` pulse.
- R5: Bit 4 (port reset, `resetReq`) is set by writing 1. Writing 0 leaves it unchanged.
- R6: `hwResetDone` while bit 4 is set clears bit 4, sets bit 1 (enabled) and sets bit 21, all on the next clock edge.
- R7: Writing 1 to bit 1 disables the port. `hwPortError` also clears bit 1 and sets bit 18.
- R8: The change flags are:
  - bit 17: connect input toggled
  - bit 18: port error
  - bit 19: warm reset done
  - bit 20: over-current input toggled
  - bit 21: reset done
  - bit 22: link update
  - bit 23: configuration error

  Each flag sets on the clock after its event, stays set until software writes 1 to it, and ignores a written 0.
- R9: When an event and a write-one clear hit the same flag in one cycle, the flag stays set.
- R10: Bits 2, 16, 24, 28, 29 and 31 always read as 0.
- R11: Writing back the current value, masked to the read-only and plain read/write bits, leaves the register unchanged.
- R12: While bit 9 is 0, bits 0 and 1 read as 0.
- R13: During reset, `rdData` reads 0x000000A0 (link state 5, RxDetect; all other bits 0), and `portPower`, `resetReq` and `linkReqValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Current register value |
| hwConnect | input | 1 | Device connected (level) |
| hwOverCurrent | input | 1 | Over-current active (level) |
| hwSpeed | input | 4 | Attached device speed code |
| hwRemovable | input | 1 | Device removable indication |
| hwLinkValid | input | 1 | Link-state update from the link (pulse) |
| hwLinkState | input | 4 | New link state given with `hwLinkValid` |
| hwResetDone | input | 1 | Port reset completed (pulse) |
| hwWarmResetDone | input | 1 | Warm reset completed (pulse) |
| hwPortError | input | 1 | Port error that disables the port (pulse) |
| hwConfigErr | input | 1 | Link configuration error (pulse) |
| portPower | output | 1 | Port power control |
| linkStateReq | output | 4 | Link state requested by the register |
| linkReqValid | output | 1 | One-cycle pulse for an accepted software link request |
| resetReq | output | 1 | Port reset request |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a hardware event meeting a write-one clear on the same flag. The other is a hardware link update meeting a strobed software link write. Only port-level stimulus can produce either one. The bench holds the event input and the write enable together for exactly one clock, then checks the flag, the link field and the request pulse in the following cycle. A vector table first takes the register through power-off masking, an all-ones write, a neutral write-back and strobe gating. Directed steps then cover reset completion, disable and each change source.

// File: rtl/pscr_pkg.sv
package pscr_pkg;
  localparam int REG_W   = 32;
  localparam int LINK_W  = 4;
  localparam int SPEED_W = 4;
  localparam int IND_W   = 2;
  localparam int WAKE_W  = 3;
  localparam int CHG_W   = 7;

  localparam int B_CONN    = 0;
  localparam int B_EN      = 1;
  localparam int B_OC      = 3;
  localparam int B_RST     = 4;
  localparam int B_LINK_LO = 5;
  localparam int B_POWER   = 9;
  localparam int B_SPD_LO  = 10;
  localparam int B_IND_LO  = 14;
  localparam int B_STROBE  = 16;
  localparam int B_CHG_LO  = 17;
  localparam int B_WAKE_LO = 25;
  localparam int B_REM     = 30;

  // change flag order inside the flag group
  localparam int C_CONN = 0;
  localparam int C_EN   = 1;
  localparam int C_WARM = 2;
  localparam int C_OC   = 3;
  localparam int C_RST  = 4;
  localparam int C_LINK = 5;
  localparam int C_CFG  = 6;

  localparam logic [LINK_W-1:0] LINK_RXDETECT = LINK_W'(5);

  typedef struct packed {
    logic              rwLoad;
    logic              powerVal;
    logic [IND_W-1:0]  indVal;
    logic [WAKE_W-1:0] wakeVal;
    logic              linkLoad;
    logic [LINK_W-1:0] linkVal;
    logic              resetSet;
    logic              enableClr;
    logic [CHG_W-1:0]  chgClr;
  } ctrl_strb_t;
endpackage

// File: rtl/pscr_ctrl.sv
module pscr_ctrl
  import pscr_pkg::*;
(
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             hwLinkValid,
  output ctrl_strb_t       strb
);
  logic unusedBits;
  assign unusedBits = ^{wrData[B_CONN], wrData[2], wrData[B_OC],
                        wrData[B_SPD_LO +: SPEED_W], wrData[24],
                        wrData[31:28]};

  always_comb begin
    strb           = '0;
    strb.rwLoad    = wrEn;
    strb.powerVal  = wrData[B_POWER];
    strb.indVal    = wrData[B_IND_LO +: IND_W];
    strb.wakeVal   = wrData[B_WAKE_LO +: WAKE_W];
    strb.linkVal   = wrData[B_LINK_LO +: LINK_W];
    // strobed link write, gated by the power value of this same write;
    // a hardware link update in the same cycle takes priority
    strb.linkLoad  = wrEn & wrData[B_STROBE] & wrData[B_POWER] & ~hwLinkValid;
    strb.resetSet  = wrEn & wrData[B_RST];
    strb.enableClr = wrEn & wrData[B_EN];
    strb.chgClr    = wrEn ? wrData[B_CHG_LO +: CHG_W] : '0;
  end
endmodule

// File: rtl/pscr_datapath.sv
module pscr_datapath
  import pscr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strb_t         strb,
  input  logic               hwConnect,
  input  logic               hwOverCurrent,
  input  logic [SPEED_W-1:0] hwSpeed,
  input  logic               hwRemovable,
  input  logic               hwLinkValid,
  input  logic [LINK_W-1:0]  hwLinkState,
  input  logic               hwResetDone,
  input  logic               hwWarmResetDone,
  input  logic               hwPortError,
  input  logic               hwConfigErr,
  output logic [REG_W-1:0]   rdData,
  output logic               portPower,
  output logic [LINK_W-1:0]  linkStateReq,
  output logic               linkReqValid,
  output logic               resetReq
);
  logic               connQ, ocQ, remQ, enQ, rstQ, powerQ, linkReqQ;
  logic [SPEED_W-1:0] speedQ;
  logic [LINK_W-1:0]  linkQ;
  logic [IND_W-1:0]   indQ;
  logic [WAKE_W-1:0]  wakeQ;
  logic [CHG_W-1:0]   chgQ;
  logic [CHG_W-1:0]   chgSet;
  logic               resetDone;

  assign resetDone = hwResetDone & rstQ;

  always_comb begin
    chgSet         = '0;
    chgSet[C_CONN] = hwConnect ^ connQ;
    chgSet[C_EN]   = hwPortError;
    chgSet[C_WARM] = hwWarmResetDone;
    chgSet[C_OC]   = hwOverCurrent ^ ocQ;
    chgSet[C_RST]  = resetDone;
    chgSet[C_LINK] = hwLinkValid;
    chgSet[C_CFG]  = hwConfigErr;
  end

  // read-only status capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      connQ  <= 1'b0;
      ocQ    <= 1'b0;
      remQ   <= 1'b0;
      speedQ <= '0;
    end else begin
      connQ  <= hwConnect;
      ocQ    <= hwOverCurrent;
      remQ   <= hwRemovable;
      speedQ <= hwSpeed;
    end
  end

  // sticky change flags: a new event outranks a clear
  for (genvar i = 0; i < CHG_W; i++) begin : g_chg
    always_ff @(posedge clk) begin
      if (!rstN) chgQ[i] <= 1'b0;
      else       chgQ[i] <= (chgQ[i] & ~strb.chgClr[i]) | chgSet[i];
    end
  end

  // control state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ      <= 1'b0;
      rstQ     <= 1'b0;
      powerQ   <= 1'b0;
      indQ     <= '0;
      wakeQ    <= '0;
      linkQ    <= LINK_RXDETECT;
      linkReqQ <= 1'b0;
    end else begin
      if (resetDone)                          enQ <= 1'b1;
      else if (hwPortError || strb.enableClr) enQ <= 1'b0;

      if (resetDone)          rstQ <= 1'b0;
      else if (strb.resetSet) rstQ <= 1'b1;

      if (strb.rwLoad) begin
        powerQ <= strb.powerVal;
        indQ   <= strb.indVal;
        wakeQ  <= strb.wakeVal;
      end

      if (hwLinkValid)        linkQ <= hwLinkState;
      else if (strb.linkLoad) linkQ <= strb.linkVal;

      linkReqQ <= strb.linkLoad;
    end
  end

  always_comb begin
    rdData                          = '0;
    rdData[B_CONN]                  = connQ & powerQ;
    rdData[B_EN]                    = enQ & powerQ;
    rdData[B_OC]                    = ocQ;
    rdData[B_RST]                   = rstQ;
    rdData[B_LINK_LO +: LINK_W]     = linkQ;
    rdData[B_POWER]                 = powerQ;
    rdData[B_SPD_LO +: SPEED_W]     = speedQ;
    rdData[B_IND_LO +: IND_W]       = indQ;
    rdData[B_CHG_LO +: CHG_W]       = chgQ;
    rdData[B_WAKE_LO +: WAKE_W]     = wakeQ;
    rdData[B_REM]                   = remQ;
  end

  assign portPower    = powerQ;
  assign linkStateReq = linkQ;
  assign linkReqValid = linkReqQ;
  assign resetReq     = rstQ;
endmodule

// File: rtl/port_status_reg.sv
module port_status_reg
  import pscr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic               hwConnect,
  input  logic               hwOverCurrent,
  input  logic [SPEED_W-1:0] hwSpeed,
  input  logic               hwRemovable,
  input  logic               hwLinkValid,
  input  logic [LINK_W-1:0]  hwLinkState,
  input  logic               hwResetDone,
  input  logic               hwWarmResetDone,
  input  logic               hwPortError,
  input  logic               hwConfigErr,
  output logic               portPower,
  output logic [LINK_W-1:0]  linkStateReq,
  output logic               linkReqValid,
  output logic               resetReq
);
  ctrl_strb_t strb;

  pscr_ctrl u_ctrl (
    .wrEn        (wrEn),
    .wrData      (wrData),
    .hwLinkValid (hwLinkValid),
    .strb        (strb)
  );

  pscr_datapath u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strb            (strb),
    .hwConnect       (hwConnect),
    .hwOverCurrent   (hwOverCurrent),
    .hwSpeed         (hwSpeed),
    .hwRemovable     (hwRemovable),
    .hwLinkValid     (hwLinkValid),
    .hwLinkState     (hwLinkState),
    .hwResetDone     (hwResetDone),
    .hwWarmResetDone (hwWarmResetDone),
    .hwPortError     (hwPortError),
    .hwConfigErr     (hwConfigErr),
    .rdData          (rdData),
    .portPower       (portPower),
    .linkStateReq    (linkStateReq),
    .linkReqValid    (linkReqValid),
    .resetReq        (resetReq)
  );
endmodule

// File: rtl/pscr_checker.sv
module pscr_checker
  import pscr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [REG_W-1:0]  wrData,
  input logic [REG_W-1:0]  rdData,
  input logic              hwLinkValid,
  input logic              hwResetDone,
  input logic              hwConfigErr,
  input logic              portPower,
  input logic [LINK_W-1:0] linkStateReq,
  input logic              linkReqValid,
  input logic              resetReq
);
  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[2] | rdData[16] | rdData[24] | rdData[28] | rdData[29] | rdData[31]) == 1'b0);

  p_power_mask_r12: assert property (@(posedge clk) disable iff (!rstN)
    !portPower |-> (rdData[B_CONN] == 1'b0 && rdData[B_EN] == 1'b0));

  p_reset_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq && hwResetDone) |=> (!resetReq && rdData[B_EN] && rdData[21]));

  p_reset_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[B_RST] && !hwResetDone) |=> resetReq);

  p_link_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[B_POWER] && !hwLinkValid) |=> ($stable(linkStateReq) && !linkReqValid));

  p_hw_link_r4: assert property (@(posedge clk) disable iff (!rstN)
    hwLinkValid |=> (rdData[22] && !linkReqValid));

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    hwConfigErr |=> rdData[23]);

  for (genvar k = B_CHG_LO; k < B_CHG_LO + CHG_W; k++) begin : g_hold
    p_chg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      (rdData[k] && !(wrEn && wrData[k])) |=> rdData[k]);
  end
endmodule

bind port_status_reg pscr_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wrEn         (wrEn),
  .wrData       (wrData),
  .rdData       (rdData),
  .hwLinkValid  (hwLinkValid),
  .hwResetDone  (hwResetDone),
  .hwConfigErr  (hwConfigErr),
  .portPower    (portPower),
  .linkStateReq (linkStateReq),
  .linkReqValid (linkReqValid),
  .resetReq     (resetReq)
);

// File: tb/tb_port_status_reg.sv
module tb_port_status_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;

  // table: write data and expected read value after that write
  localparam logic [31:0] VEC_WR [NVEC] = '{
    32'h0000_0200,  // R2 power on, R12 mask lifts
    32'hFFFF_FFFF,  // R1 R3 R5 R10 all ones
    32'h4E00_CFE1,  // R11 neutral write-back
    32'h0000_0000,  // R2 R5 R12 zero write
    32'h0001_0060,  // R3 strobe with power 0: ignored
    32'h0001_0260,  // R3 strobe with power 1: link 3
    32'h0000_0200   // R3 no strobe: link held
  };
  localparam logic [31:0] VEC_EXP [NVEC] = '{
    32'h4002_0EA1,
    32'h4E00_CFF1,
    32'h4E00_CFF1,
    32'h4000_0DF0,
    32'h4000_0DF0,
    32'h4000_0E71,
    32'h4000_0E71
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        hwConnect = 1'b1;
  logic        hwOverCurrent = 1'b0;
  logic [3:0]  hwSpeed = 4'h3;
  logic        hwRemovable = 1'b1;
  logic        hwLinkValid = 1'b0;
  logic [3:0]  hwLinkState = '0;
  logic        hwResetDone = 1'b0;
  logic        hwWarmResetDone = 1'b0;
  logic        hwPortError = 1'b0;
  logic        hwConfigErr = 1'b0;
  logic        portPower, linkReqValid, resetReq;
  logic [3:0]  linkStateReq;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_status_reg dut (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got=%08h expected=%08h", req, got, exp);
    end
  endtask

  task automatic regWrite(input logic [31:0] d);
    wrEn = 1'b1; wrData = d;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog got=%08h expected=%08h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // R13 reset state
    repeat (3) tick();
    check("R13 rdData", rdData, 32'h0000_00A0);
    check("R13 outputs", {29'd0, portPower, resetReq, linkReqValid}, 32'd0);
    rstN = 1'b1;
    tick();
    // R1 inputs appear, R8 connect toggle flag, R12 connect masked
    check("R1 R8 after reset", rdData, 32'h4002_0CA0);

    for (int i = 0; i < NVEC; i++) begin
      regWrite(VEC_WR[i]);
      check($sformatf("vector %0d R1-R12 table", i), rdData, VEC_EXP[i]);
    end
    check("R2 portPower", {31'd0, portPower}, 32'd1);
    check("R5 resetReq held", {31'd0, resetReq}, 32'd1);

    // R3 accepted strobe: pulse and request
    regWrite(32'h0001_0240);
    check("R3 req pulse", {27'd0, linkReqValid, linkStateReq}, {27'd0, 1'b1, 4'd2});
    tick();
    check("R3 pulse ends", {31'd0, linkReqValid}, 32'd0);
    check("R3 state", rdData, 32'h4000_0E51);

    // R6 reset completion
    hwResetDone = 1'b1; tick(); hwResetDone = 1'b0;
    check("R6 reset done", rdData, 32'h4020_0E43);
    regWrite(32'h0020_0200);
    check("R8 clear reset change", rdData, 32'h4000_0E43);

    // R7 software disable
    regWrite(32'h0000_0202);
    check("R7 disable", rdData, 32'h4000_0E41);
    hwPortError = 1'b1; tick(); hwPortError = 1'b0;
    check("R7 R8 port error", rdData, 32'h4004_0E41);

    // R9 event and clear together
    hwPortError = 1'b1; wrEn = 1'b1; wrData = 32'h0004_0200;
    tick();
    hwPortError = 1'b0; wrEn = 1'b0; wrData = '0;
    check("R9 event wins", rdData, 32'h4004_0E41);
    regWrite(32'h0000_0200);
    check("R8 zero write keeps flag", rdData, 32'h4004_0E41);
    regWrite(32'h0004_0200);
    check("R8 clear enable change", rdData, 32'h4000_0E41);

    // R1 R8 connect drop
    hwConnect = 1'b0; tick();
    check("R1 R8 disconnect", rdData, 32'h4002_0E40);
    regWrite(32'h4000_3E09);
    check("R1 RO write ignored", rdData, 32'h4002_0E40);

    // R8 over-current toggle
    hwOverCurrent = 1'b1; tick();
    check("R1 R8 over-current", rdData, 32'h4012_0E48);

    // R4 hardware link update beats software strobe
    hwLinkValid = 1'b1; hwLinkState = 4'd0; wrEn = 1'b1; wrData = 32'h0001_0260;
    tick();
    hwLinkValid = 1'b0; wrEn = 1'b0; wrData = '0;
    check("R4 hw link wins", rdData, 32'h4052_0E08);
    check("R4 no req pulse", {31'd0, linkReqValid}, 32'd0);

    // R8 remaining sources
    hwWarmResetDone = 1'b1; tick(); hwWarmResetDone = 1'b0;
    check("R8 warm reset change", rdData, 32'h405A_0E08);
    hwConfigErr = 1'b1; tick(); hwConfigErr = 1'b0;
    check("R8 config error change", rdData, 32'h40DA_0E08);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule